// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave Interface

This block is the slave side of a three-wire serial memory link. The link has a chip select, a serial clock, a serial data input and a data output with its own output enable. The bus master sends a command of one start bit, a two-bit opcode and an address, plus a data word for the writing commands. The block decodes the command and either shifts out a stored word or issues a write to a small internal register-file memory. Write completion is timed by a programmable busy counter. While a write is in progress, the block can report ready or busy on the data output. That status is released by clocking in a dummy one, so the input and output can share a single wire.

All serial inputs are sampled by the system clock. They are treated as synchronous to it and are much slower than it, so rising and falling edges of the serial clock are detected as events. A parameter selects the organisation. The 16-bit-word organisation uses `ADDR_BASE` address bits. The 8-bit-word organisation uses one more address bit and an 8-bit data word.

Top module: `mw_eeprom_slave`

## Requirements
- R1: While chip select is high, the data input is sampled at each rising serial-clock edge. Zeros before the start bit are ignored. A command is a start bit of 1, then a two-bit opcode (MSB first), then AW address bits (MSB first), then DW data bits (MSB first) for the two writing commands. AW = 6 and DW = 16 by default.
- R2: Opcode 10 is a read. At the rising edge that samples the last address bit, the output is enabled and drives a dummy 0. Each later rising edge presents the next data bit, MSB first. The rising edge after the LSB disables the output.
- R3: Opcode 01 stores the data word at the address. Opcode 11 sets the addressed word to all ones.
- R4: Opcode 00 takes a sub-command from the top two address bits: 11 enables writes, 00 disables writes, 10 sets every word to all ones, and 01 writes the following data word to every word.
- R5: Single writes, single erases, erase-all and write-all have no effect, and start no busy period, unless writes were enabled after reset and not disabled since.
- R6: An accepted write keeps the block busy for BUSY_CYCLES system-clock cycles. While it is busy, start bits are ignored and no command begins.
- R7: On the first chip-select rise after an accepted write, the output is enabled and shows status: 0 while busy, 1 once ready. The status follows completion while chip select stays high.
- R8: A 1 sampled while status is shown returns the output to high impedance after the next falling serial-clock edge. That 1 is not taken as a start bit. Lowering chip select also ends the status report.
- R9: Lowering chip select aborts any partly received command, so no write takes place. The output is disabled while chip select is low.
- R10: After reset the output is disabled, every word reads as zero, writes are disabled and the block is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the master |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Output enable for sdo_o (0 = high impedance) |

## Verification
Status reporting and write completion can fall in the same window. The master raises chip select while the busy counter is still running and holds it high. The data output must then change from 0 to 1 on its own when the counter expires, with no further chip-select edge. The bench samples the output a few cycles after the rise and again after the full busy time. It also checks that the dummy one which ends the report does not start a command: a full read sent right after it, while still busy, must leave the output disabled.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_DONE
    } dec_state_e;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } opcode_e;

    typedef enum logic [1:0] {
        SUB_DISABLE  = 2'b00,
        SUB_FILLALL  = 2'b01,
        SUB_CLEARALL = 2'b10,
        SUB_ENABLE   = 2'b11
    } subop_e;

    typedef enum logic [2:0] {
        RQ_NONE,
        RQ_ONE,
        RQ_ALL,
        RQ_EN,
        RQ_DIS
    } req_kind_e;

    typedef struct packed {
        logic sk_rise;
        logic sk_fall;
        logic cs_rise;
        logic cs_fall;
    } mw_edges_t;

    function automatic int addr_bits(input int word16, input int base);
        return (word16 != 0) ? base : base + 1;
    endfunction

    function automatic int data_bits(input int word16);
        return (word16 != 0) ? 16 : 8;
    endfunction

endpackage

// File: rtl/mw_edge.sv
module mw_edge
    import mw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk_i,
    input  logic      cs_i,
    output mw_edges_t ev_o
);
    logic sk_q;
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sk_q <= 1'b0;
            cs_q <= 1'b0;
        end else begin
            sk_q <= sclk_i;
            cs_q <= cs_i;
        end
    end

    always_comb begin
        ev_o.sk_rise = sclk_i & ~sk_q;
        ev_o.sk_fall = ~sclk_i & sk_q;
        ev_o.cs_rise = cs_i & ~cs_q;
        ev_o.cs_fall = ~cs_i & cs_q;
    end

endmodule

// File: rtl/mw_store.sv
module mw_store
    import mw_pkg::*;
#(
    parameter int AW          = 6,
    parameter int DW          = 16,
    parameter int BUSY_CYCLES = 200
) (
    input  logic          clk,
    input  logic          rst,
    input  req_kind_e     req_kind_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    output logic          busy_o,
    output logic          accept_o
);
    localparam int DEPTH = 1 << AW;
    localparam int BCW   = $clog2(BUSY_CYCLES + 1);
    localparam logic [BCW-1:0] BUSY_LOAD = BCW'(BUSY_CYCLES);

    logic [DW-1:0]  mem [DEPTH];
    logic           wen_q;
    logic [BCW-1:0] bcnt_q;
    logic           is_write;
    logic           wr_go;

    assign is_write  = (req_kind_i == RQ_ONE) || (req_kind_i == RQ_ALL);
    assign wr_go     = is_write && wen_q && !busy_o;
    assign busy_o    = (bcnt_q != '0);
    assign rd_data_o = mem[rd_addr_i];

    always_ff @(posedge clk) begin
        if (rst) begin
            wen_q    <= 1'b0;
            bcnt_q   <= '0;
            accept_o <= 1'b0;
        end else begin
            accept_o <= wr_go;
            if (req_kind_i == RQ_EN) begin
                wen_q <= 1'b1;
            end else if (req_kind_i == RQ_DIS) begin
                wen_q <= 1'b0;
            end
            if (wr_go) begin
                bcnt_q <= BUSY_LOAD;
            end else if (bcnt_q != '0) begin
                bcnt_q <= bcnt_q - BCW'(1);
            end
        end
    end

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[w] <= '0;
            end else if (wr_go && ((req_kind_i == RQ_ALL) || (req_addr_i == AW'(w)))) begin
                mem[w] <= req_data_i;
            end
        end
    end

    AST_LOCKED_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
        (is_write && !wen_q && !busy_o) |=> !busy_o); // R5

    AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !is_write); // R6

endmodule

// File: rtl/mw_cmd.sv
module mw_cmd
    import mw_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_i,
    input  logic          sdi_i,
    input  mw_edges_t     ev_i,
    input  logic          busy_i,
    input  logic          accept_i,
    input  logic [DW-1:0] rd_data_i,
    output req_kind_e     req_kind_o,
    output logic [AW-1:0] req_addr_o,
    output logic [DW-1:0] req_data_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          sdo_o,
    output logic          sdo_oe_o
);
    localparam int CW = $clog2(((AW > DW) ? AW : DW) + 1);
    localparam logic [CW-1:0] LAST_A = CW'(AW - 1);
    localparam logic [CW-1:0] LAST_D = CW'(DW - 1);
    localparam logic [CW-1:0] FULL_D = CW'(DW);

    dec_state_e    st_q;
    opcode_e       opc_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [CW-1:0] cnt_q;
    req_kind_e     req_q;
    logic          rd_oe_q;
    logic          rd_bit_q;
    logic          load_q;
    logic          show_q;
    logic          dismiss_q;
    logic          pend_q;
    logic [AW-1:0] full_addr;

    assign full_addr  = {addr_q[AW-2:0], sdi_i};
    assign req_kind_o = req_q;
    assign req_addr_o = addr_q;
    assign req_data_o = data_q;
    assign rd_addr_o  = addr_q;
    assign sdo_o      = show_q ? !busy_i : rd_bit_q;
    assign sdo_oe_o   = show_q | rd_oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            opc_q     <= OP_EXT;
            addr_q    <= '0;
            data_q    <= '0;
            cnt_q     <= '0;
            req_q     <= RQ_NONE;
            rd_oe_q   <= 1'b0;
            rd_bit_q  <= 1'b0;
            load_q    <= 1'b0;
            show_q    <= 1'b0;
            dismiss_q <= 1'b0;
            pend_q    <= 1'b0;
        end else begin
            req_q <= RQ_NONE;
            if (accept_i) begin
                pend_q <= 1'b1;
            end
            if (load_q) begin
                data_q <= rd_data_i;
                load_q <= 1'b0;
            end
            if (!cs_i) begin
                st_q      <= ST_IDLE;
                cnt_q     <= '0;
                rd_oe_q   <= 1'b0;
                show_q    <= 1'b0;
                dismiss_q <= 1'b0;
                if (ev_i.cs_fall && show_q) begin
                    pend_q <= 1'b0;
                end
            end else if (ev_i.cs_rise && pend_q) begin
                show_q <= 1'b1;
            end else if (show_q) begin
                if (ev_i.sk_rise && sdi_i) begin
                    dismiss_q <= 1'b1;
                end
                if (ev_i.sk_fall && dismiss_q) begin
                    show_q    <= 1'b0;
                    dismiss_q <= 1'b0;
                    pend_q    <= 1'b0;
                end
            end else if (ev_i.sk_rise) begin
                unique case (st_q)
                    ST_IDLE: begin
                        if (sdi_i && !busy_i) begin
                            st_q  <= ST_OPC;
                            cnt_q <= '0;
                        end
                    end
                    ST_OPC: begin
                        opc_q <= opcode_e'({opc_q[0], sdi_i});
                        if (cnt_q == CW'(1)) begin
                            st_q  <= ST_ADDR;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    ST_ADDR: begin
                        addr_q <= full_addr;
                        if (cnt_q == LAST_A) begin
                            cnt_q <= '0;
                            st_q  <= ST_DONE;
                            unique case (opc_q)
                                OP_READ: begin
                                    st_q     <= ST_READ;
                                    rd_oe_q  <= 1'b1;
                                    rd_bit_q <= 1'b0;
                                    load_q   <= 1'b1;
                                end
                                OP_WRITE: st_q <= ST_DATA;
                                OP_ERASE: begin
                                    req_q  <= RQ_ONE;
                                    data_q <= '1;
                                end
                                OP_EXT: begin
                                    unique case (subop_e'(full_addr[AW-1:AW-2]))
                                        SUB_ENABLE:  req_q <= RQ_EN;
                                        SUB_DISABLE: req_q <= RQ_DIS;
                                        SUB_CLEARALL: begin
                                            req_q  <= RQ_ALL;
                                            data_q <= '1;
                                        end
                                        SUB_FILLALL: st_q <= ST_DATA;
                                    endcase
                                end
                            endcase
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    ST_DATA: begin
                        data_q <= {data_q[DW-2:0], sdi_i};
                        if (cnt_q == LAST_D) begin
                            req_q <= (opc_q == OP_WRITE) ? RQ_ONE : RQ_ALL;
                            st_q  <= ST_DONE;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    ST_READ: begin
                        if (cnt_q == FULL_D) begin
                            rd_oe_q <= 1'b0;
                            st_q    <= ST_DONE;
                        end else begin
                            rd_bit_q <= data_q[DW-1];
                            data_q   <= {data_q[DW-2:0], 1'b0};
                            cnt_q    <= cnt_q + CW'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_HIZ_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        !cs_i |=> !sdo_oe_o); // R9

    AST_DISMISS_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (cs_i && show_q && dismiss_q && ev_i.sk_fall) |=> !sdo_oe_o); // R8

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && busy_i) |=> (st_q == ST_IDLE)); // R6

    AST_READ_DUMMY_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_oe_q) |-> !sdo_o); // R2

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && !show_q) |-> !sdo_oe_o); // R1

endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
    import mw_pkg::*;
#(
    parameter int WORD16      = 1,
    parameter int ADDR_BASE   = 6,
    parameter int BUSY_CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic sdo_o,
    output logic sdo_oe_o
);
    localparam int AW = addr_bits(WORD16, ADDR_BASE);
    localparam int DW = data_bits(WORD16);

    mw_edges_t     ev;
    req_kind_e     req_kind;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          busy;
    logic          accept;

    mw_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk_i),
        .cs_i   (cs_i),
        .ev_o   (ev)
    );

    mw_cmd #(.AW(AW), .DW(DW)) u_cmd (
        .clk        (clk),
        .rst        (rst),
        .cs_i       (cs_i),
        .sdi_i      (sdi_i),
        .ev_i       (ev),
        .busy_i     (busy),
        .accept_i   (accept),
        .rd_data_i  (rd_data),
        .req_kind_o (req_kind),
        .req_addr_o (req_addr),
        .req_data_o (req_data),
        .rd_addr_o  (rd_addr),
        .sdo_o      (sdo_o),
        .sdo_oe_o   (sdo_oe_o)
    );

    mw_store #(.AW(AW), .DW(DW), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
        .clk        (clk),
        .rst        (rst),
        .req_kind_i (req_kind),
        .req_addr_i (req_addr),
        .req_data_i (req_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .busy_o     (busy),
        .accept_o   (accept)
    );

endmodule

// File: tb/mw_eeprom_slave_test.sv
`timescale 1ns/1ps
module mw_eeprom_slave_test;
    localparam int H    = 4;
    localparam int AW   = 6;
    localparam int DW   = 16;
    localparam int BUSY = 200;
    localparam int NVEC = 5;
    localparam logic [AW+DW-1:0] VECS [NVEC] = '{
        {6'd0,  16'hA5A5},
        {6'd63, 16'h5A5A},
        {6'd17, 16'hFFFF},
        {6'd42, 16'h0001},
        {6'd9,  16'h8000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs  = 1'b0;
    logic sk  = 1'b0;
    logic di  = 1'b0;
    logic sdo;
    logic oe;
    int   nchk = 0;
    int   nerr = 0;

    always #10 clk = ~clk;

    mw_eeprom_slave #(.WORD16(1), .ADDR_BASE(AW), .BUSY_CYCLES(BUSY)) uut (
        .clk      (clk),
        .rst      (rst),
        .cs_i     (cs),
        .sclk_i   (sk),
        .sdi_i    (di),
        .sdo_o    (sdo),
        .sdo_oe_o (oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clk_bit(input logic b, output logic d, output logic e);
        di = b;
        repeat (H) @(negedge clk);
        sk = 1'b1;
        repeat (H) @(negedge clk);
        d  = sdo;
        e  = oe;
        sk = 1'b0;
    endtask

    task automatic select_dev();
        @(negedge clk);
        sk = 1'b0;
        cs = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic deselect_dev();
        @(negedge clk);
        sk = 1'b0;
        cs = 1'b0;
        di = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [AW-1:0] a, input int nz,
                            output logic d, output logic e);
        for (int i = 0; i < nz; i++) clk_bit(1'b0, d, e);
        clk_bit(1'b1, d, e);
        clk_bit(op[1], d, e);
        clk_bit(op[0], d, e);
        for (int i = AW - 1; i >= 0; i--) clk_bit(a[i], d, e);
    endtask

    task automatic send_data(input logic [DW-1:0] v, input int n);
        logic d, e;
        for (int i = 0; i < n; i++) clk_bit(v[DW-1-i], d, e);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] v);
        logic d, e;
        select_dev();
        send_hdr(2'b01, a, 0, d, e);
        send_data(v, DW);
        deselect_dev();
    endtask

    task automatic do_erase(input logic [AW-1:0] a);
        logic d, e;
        select_dev();
        send_hdr(2'b11, a, 0, d, e);
        deselect_dev();
    endtask

    task automatic do_ext(input logic [1:0] sub, input logic [DW-1:0] v, input bit with_data);
        logic d, e;
        select_dev();
        send_hdr(2'b00, {sub, {(AW-2){1'b0}}}, 0, d, e);
        if (with_data) send_data(v, DW);
        deselect_dev();
    endtask

    task automatic wait_done(input string tag);
        select_dev();
        repeat (4) @(negedge clk);
        check({tag, " R7 busy status"}, {30'd0, oe, sdo}, 32'd2);
        repeat (BUSY) @(negedge clk);
        check({tag, " R7 ready status"}, {30'd0, oe, sdo}, 32'd3);
        deselect_dev();
    endtask

    task automatic no_status(input string tag);
        select_dev();
        repeat (4) @(negedge clk);
        check(tag, {31'd0, oe}, 32'd0);
        deselect_dev();
    endtask

    task automatic do_read(input logic [AW-1:0] a, input int nz, output logic [DW-1:0] v);
        logic d, e;
        select_dev();
        send_hdr(2'b10, a, nz, d, e);
        check("R2 dummy zero with output enabled", {30'd0, e, d}, 32'd2);
        for (int i = DW - 1; i >= 0; i--) begin
            clk_bit(1'b0, d, e);
            v[i] = d;
        end
        clk_bit(1'b0, d, e);
        check("R2 output released after LSB", {31'd0, e}, 32'd0);
        deselect_dev();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [DW-1:0] rv;
        logic d, e;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 output disabled after reset", {31'd0, oe}, 32'd0);
        do_read(6'd3, 0, rv);
        check("R10 memory zero after reset", {16'd0, rv}, 32'd0);

        // R5: writes locked after reset
        do_write(6'd5, 16'h1234);
        no_status("R5 no status for locked write");
        do_read(6'd5, 0, rv);
        check("R5 locked write ignored", {16'd0, rv}, 32'd0);

        // R4: enable sub-command
        do_ext(2'b11, '0, 1'b0);

        // R3: table of write/read-back vectors
        for (int k = 0; k < NVEC; k++) begin
            do_write(VECS[k][AW+DW-1:DW], VECS[k][DW-1:0]);
            wait_done("R3 write");
            do_read(VECS[k][AW+DW-1:DW], 0, rv);
            check("R3 write read-back", {16'd0, rv}, {16'd0, VECS[k][DW-1:0]});
        end

        // R1: leading zeros before start bit
        do_read(6'd0, 3, rv);
        check("R1 leading zeros ignored", {16'd0, rv}, 32'h0000A5A5);

        // R3: single erase
        do_erase(6'd42);
        wait_done("R3 erase");
        do_read(6'd42, 0, rv);
        check("R3 erase gives all ones", {16'd0, rv}, 32'h0000FFFF);

        // R8 and R6: dismiss status, then a read while busy is ignored
        do_write(6'd9, 16'h1111);
        select_dev();
        repeat (4) @(negedge clk);
        check("R7 busy on select", {30'd0, oe, sdo}, 32'd2);
        clk_bit(1'b1, d, e);
        check("R8 status held until falling edge", {31'd0, e}, 32'd1);
        repeat (3) @(negedge clk);
        check("R8 output released after dummy one", {31'd0, oe}, 32'd0);
        begin
            logic seen;
            seen = 1'b0;
            clk_bit(1'b1, d, e);
            seen = seen | e;
            clk_bit(1'b1, d, e);
            seen = seen | e;
            clk_bit(1'b0, d, e);
            seen = seen | e;
            for (int i = 0; i < AW + 2; i++) begin
                clk_bit(1'b0, d, e);
                seen = seen | e;
            end
            check("R6 command ignored while busy", {31'd0, seen}, 32'd0);
        end
        deselect_dev();
        repeat (BUSY + 20) @(negedge clk);
        do_read(6'd9, 0, rv);
        check("R6 write completed", {16'd0, rv}, 32'h00001111);

        // R9: aborted write
        select_dev();
        send_hdr(2'b01, 6'd9, 0, d, e);
        send_data(16'hBEEF, 8);
        deselect_dev();
        no_status("R9 aborted write not accepted");
        do_read(6'd9, 0, rv);
        check("R9 aborted write left word unchanged", {16'd0, rv}, 32'h00001111);

        // R9: aborted read releases output
        select_dev();
        send_hdr(2'b10, 6'd9, 0, d, e);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, d, e);
        @(negedge clk);
        cs = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 output off when deselected", {31'd0, oe}, 32'd0);
        repeat (3) @(negedge clk);

        // R4: write-all and erase-all
        do_ext(2'b01, 16'h3C3C, 1'b1);
        wait_done("R4 write-all");
        do_read(6'd0, 0, rv);
        check("R4 write-all word 0", {16'd0, rv}, 32'h00003C3C);
        do_read(6'd63, 0, rv);
        check("R4 write-all word 63", {16'd0, rv}, 32'h00003C3C);
        do_ext(2'b10, '0, 1'b0);
        wait_done("R4 erase-all");
        do_read(6'd30, 0, rv);
        check("R4 erase-all word 30", {16'd0, rv}, 32'h0000FFFF);

        // R5: disable sub-command locks writes again
        do_ext(2'b00, '0, 1'b0);
        do_write(6'd5, 16'h7777);
        no_status("R5 no status after disable");
        do_read(6'd5, 0, rv);
        check("R5 write after disable ignored", {16'd0, rv}, 32'h0000FFFF);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule